// File: doc/BRIEF.md
# Target Serial Programming Decoder

This block sits on the device side of an in-system programming link. A host drives a slow serial clock and data line in SPI mode 0 (data sampled on the rising edge, most significant bit first). The block oversamples both lines with the system clock and groups the bits into four-byte instructions. Each complete instruction is decoded into one of these actions:
- arming the link;
- loading one byte into a word-organised page buffer;
- committing that buffer to a page of program memory;
- writing or reading a byte of data EEPROM;
- setting a sticky extended address byte;
- erasing the whole of both memories.

All traffic to the memories goes through a memory request port. The port drives a small behavioural model of the flash and EEPROM, and it is also visible at the top level. Every write or erase keeps a busy flag high for a fixed number of system clocks. Instructions that finish while the flag is high have no effect.

The reply line always returns the previously received byte, one byte late. The only exception is the fourth byte of a read instruction, which carries the memory data. The host uses the returned 0x53 to confirm that it is in frame sync.

The behavioural flash holds 2^FLASH_AW words. It keeps bit 16 of the 24-bit word address and the low FLASH_AW-1 bits, so pages under both extended byte values stay distinct. The EEPROM uses the low EE_AW address bits.

Top module: `tsp_target`

## Requirements
- R1: Bits are taken on rising serial clock edges, most significant bit first, and every 32 bits form one instruction. While prog_en is low, the bit and byte counters return to the first bit of byte 0, the armed state clears and the reply byte becomes 0x00.
- R2: While bytes 1, 2 and 3 are received, miso shifts out the byte received just before. During byte 0 it shifts out 0x00, so the arming instruction returns 0x53 during its third byte.
- R3: No instruction other than arming (bytes 0xAC 0x53) has any effect until an arming instruction has completed.
- R4: Opcode 0x40 writes byte 3 into the low half of buffer word byte2[6:0] and sets that word's high half to 0xFF. Opcode 0x48 writes byte 3 into the high half only. Loading low then high keeps both halves.
- R5: Opcode 0x4C copies the whole buffer into the page at word address {ext, byte1, byte2}, with the low 7 bits ignored. The buffer then reads as all 0xFFFF.
- R6: Opcode 0x4D stores byte 2 as the extended byte. It keeps that value across later instructions and gives address bits 23:16 to page writes and flash reads.
- R7: Opcode 0x20 (low half) and opcode 0x28 (high half) read flash word {ext, byte1, byte2}. The result is shifted out during byte 3.
- R8: Opcode 0xC0 stores byte 3 at EEPROM address {byte1, byte2}, replacing the old value outright. Opcode 0xA0 returns that byte during byte 3.
- R9: Instruction 0xAC 0x80 sets every flash word and every EEPROM byte to all ones.
- R10: The busy flag stays high for exactly 45, 36 and 90 times TICK system clocks after a page write, an EEPROM write and a chip erase respectively.
- R11: An instruction whose last byte completes while busy is high changes nothing.
- R12: req_valid pulses for one clock per accepted memory action. req_op uses these codes: 1 page write, 2 EEPROM write, 3 chip erase, 4 flash read, 5 EEPROM read. req_addr carries the 24-bit address and req_data carries the write byte, or the half select for flash reads. After reset, busy, req_valid and miso are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Programming enable; low resets framing and arming |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply to the host |
| busy | output | 1 | High while a write or erase is in progress |
| req_valid | output | 1 | One-clock memory request strobe |
| req_op | output | 3 | Memory request kind |
| req_addr | output | 24 | Memory request address |
| req_data | output | 8 | Write data, or half select for flash reads |

## Verification
Most wrong internal states show up on miso within a single instruction. A framing slip or a stale reply register corrupts the echoed bytes, including the 0x53 in the third byte of the arming instruction. A wrong extended byte, a wrong buffer byte or a bad byte-order rule only shows later, when a read instruction returns the wrong data in its fourth byte. A wrong busy counter shows as a busy pulse of the wrong length, and it is measured from the end of the instruction that started it.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PAGE_WR = 3'd1,
    OP_EE_WR   = 3'd2,
    OP_ERASE   = 3'd3,
    OP_RD_FL   = 3'd4,
    OP_RD_EE   = 3'd5
  } mem_op_e;

  localparam logic [7:0] CMD_ARM  = 8'hAC;
  localparam logic [7:0] CMD_SYNC = 8'h53;
  localparam logic [7:0] CMD_WIPE = 8'h80;
  localparam logic [7:0] CMD_EXT  = 8'h4D;
  localparam logic [7:0] CMD_LDLO = 8'h40;
  localparam logic [7:0] CMD_LDHI = 8'h48;
  localparam logic [7:0] CMD_PGWR = 8'h4C;
  localparam logic [7:0] CMD_RDLO = 8'h20;
  localparam logic [7:0] CMD_RDHI = 8'h28;
  localparam logic [7:0] CMD_EEWR = 8'hC0;
  localparam logic [7:0] CMD_EERD = 8'hA0;

  // Busy length in clocks; tick is clocks per 100 us
  function automatic logic [31:0] busy_ticks(mem_op_e op, logic [31:0] tick);
    case (op)
      OP_PAGE_WR: return 32'd45 * tick;
      OP_EE_WR:   return 32'd36 * tick;
      OP_ERASE:   return 32'd90 * tick;
      default:    return 32'd0;
    endcase
  endfunction

  // Fold a 24-bit word address into the small flash model
  function automatic logic [31:0] flash_fold(logic [23:0] wa, int unsigned aw);
    logic [31:0] low_mask;
    low_mask = (32'd1 << (aw - 1)) - 32'd1;
    return ({31'd0, wa[16]} << (aw - 1)) | ({16'd0, wa[15:0]} & low_mask);
  endfunction
endpackage

// File: rtl/tsp_spi_rx.sv
module tsp_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_en,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] tx_next,
  output logic       byte_done,
  output logic [1:0] byte_idx,
  output logic [7:0] rx_byte,
  output logic [7:0] tx_cur,
  output logic       miso
);
  logic [2:0] sck_s;
  logic [1:0] mosi_s;
  logic [6:0] shreg;
  logic [2:0] bit_cnt;
  logic       rise;

  assign rise      = sck_s[1] & ~sck_s[2];
  assign byte_done = prog_en & rise & (bit_cnt == 3'd7);
  assign rx_byte   = {shreg, mosi_s[1]};
  assign miso      = tx_cur[~bit_cnt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s    <= '0;
      mosi_s   <= '0;
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      tx_cur   <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      if (!prog_en) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
        tx_cur   <= '0;
      end else if (rise) begin
        shreg   <= {shreg[5:0], mosi_s[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_idx <= byte_idx + 2'd1;
          tx_cur   <= tx_next;
        end
      end
    end
  end
endmodule

// File: rtl/tsp_page_buf.sv
module tsp_page_buf #(
  parameter  int PAGE_AW    = 7,
  localparam int PAGE_WORDS = 1 << PAGE_AW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic                          ld_hi,
  input  logic [PAGE_AW-1:0]            ld_idx,
  input  logic [7:0]                    ld_data,
  input  logic                          clr,
  output logic [PAGE_WORDS-1:0][15:0]   words
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '1;
    end else if (clr) begin
      words <= '1;
    end else if (ld_en) begin
      if (ld_hi) words[ld_idx][15:8] <= ld_data;
      else       words[ld_idx]       <= {8'hFF, ld_data};
    end
  end
endmodule

// File: rtl/tsp_mem_model.sv
module tsp_mem_model
  import tsp_pkg::*;
#(
  parameter  int FLASH_AW   = 10,
  parameter  int EE_AW      = 8,
  parameter  int PAGE_AW    = 7,
  localparam int FL_WORDS   = 1 << FLASH_AW,
  localparam int EE_BYTES   = 1 << EE_AW,
  localparam int PAGE_WORDS = 1 << PAGE_AW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  mem_op_e                      req_op,
  input  logic [23:0]                  req_addr,
  input  logic [7:0]                   req_data,
  input  logic [PAGE_WORDS-1:0][15:0]  page,
  output logic [7:0]                   rd_data
);
  logic [15:0] flash  [FL_WORDS];
  logic [7:0]  eeprom [EE_BYTES];
  logic        do_erase, do_page, do_ee;
  logic [23:0] page_base;
  logic [15:0] rd_word;

  assign do_erase  = req_valid && (req_op == OP_ERASE);
  assign do_page   = req_valid && (req_op == OP_PAGE_WR);
  assign do_ee     = req_valid && (req_op == OP_EE_WR);
  assign page_base = {req_addr[23:PAGE_AW], {PAGE_AW{1'b0}}};
  assign rd_word   = flash[FLASH_AW'(flash_fold(req_addr, FLASH_AW))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FL_WORDS; i++) flash[i] <= 16'hFFFF;
    end else if (do_erase) begin
      for (int i = 0; i < FL_WORDS; i++) flash[i] <= 16'hFFFF;
    end else if (do_page) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        flash[FLASH_AW'(flash_fold(page_base | 24'(w), FLASH_AW))] <= page[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < EE_BYTES; i++) eeprom[i] <= 8'hFF;
    end else if (do_erase) begin
      for (int i = 0; i < EE_BYTES; i++) eeprom[i] <= 8'hFF;
    end else if (do_ee) begin
      eeprom[req_addr[EE_AW-1:0]] <= req_data;
    end
  end

  always_comb begin
    case (req_op)
      OP_RD_FL: rd_data = req_data[0] ? rd_word[15:8] : rd_word[7:0];
      OP_RD_EE: rd_data = eeprom[req_addr[EE_AW-1:0]];
      default:  rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/tsp_decode.sv
module tsp_decode
  import tsp_pkg::*;
#(
  parameter int PAGE_AW = 7,
  parameter int TICK    = 1600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_en,
  input  logic               byte_done,
  input  logic [1:0]         byte_idx,
  input  logic [7:0]         rx_byte,
  input  logic [7:0]         rd_data,
  output logic [7:0]         tx_next,
  output logic               req_valid,
  output mem_op_e            req_op,
  output logic [23:0]        req_addr,
  output logic [7:0]         req_data,
  output logic               ld_en,
  output logic               ld_hi,
  output logic [PAGE_AW-1:0] ld_idx,
  output logic [7:0]         ld_data,
  output logic               buf_clr,
  output logic               busy,
  output logic               armed
);
  logic [7:0]  b0, b1, b2, ext;
  logic [31:0] busy_cnt;
  logic        live, mid_done, frame_done, is_read;

  assign live       = armed && !busy;
  assign mid_done   = byte_done && (byte_idx == 2'd2);
  assign frame_done = byte_done && (byte_idx == 2'd3);
  assign busy       = busy_cnt != 32'd0;
  assign is_read    = req_valid && (req_op == OP_RD_FL || req_op == OP_RD_EE);

  always_comb begin
    req_valid = 1'b0;
    req_op    = OP_NONE;
    req_addr  = '0;
    req_data  = '0;
    ld_en     = 1'b0;
    ld_hi     = 1'b0;
    ld_idx    = '0;
    ld_data   = '0;
    buf_clr   = 1'b0;
    if (mid_done && live) begin
      if (b0 == CMD_RDLO || b0 == CMD_RDHI) begin
        req_valid = 1'b1;
        req_op    = OP_RD_FL;
        req_addr  = {ext, b1, rx_byte};
        req_data  = {7'd0, b0 == CMD_RDHI};
      end else if (b0 == CMD_EERD) begin
        req_valid = 1'b1;
        req_op    = OP_RD_EE;
        req_addr  = {8'h00, b1, rx_byte};
      end
    end
    if (frame_done && live) begin
      case (b0)
        CMD_ARM: if (b1 == CMD_WIPE) begin
          req_valid = 1'b1;
          req_op    = OP_ERASE;
        end
        CMD_LDLO, CMD_LDHI: begin
          ld_en   = 1'b1;
          ld_hi   = (b0 == CMD_LDHI);
          ld_idx  = b2[PAGE_AW-1:0];
          ld_data = rx_byte;
        end
        CMD_PGWR: begin
          req_valid = 1'b1;
          req_op    = OP_PAGE_WR;
          req_addr  = {ext, b1, b2};
          buf_clr   = 1'b1;
        end
        CMD_EEWR: begin
          req_valid = 1'b1;
          req_op    = OP_EE_WR;
          req_addr  = {8'h00, b1, b2};
          req_data  = rx_byte;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (byte_idx == 2'd3) tx_next = 8'h00;
    else if (is_read)     tx_next = rd_data;
    else                  tx_next = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0       <= '0;
      b1       <= '0;
      b2       <= '0;
      ext      <= '0;
      armed    <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (byte_done) begin
        case (byte_idx)
          2'd0:    b0 <= rx_byte;
          2'd1:    b1 <= rx_byte;
          2'd2:    b2 <= rx_byte;
          default: ;
        endcase
      end
      if (!prog_en) armed <= 1'b0;
      else if (frame_done && !busy && b0 == CMD_ARM && b1 == CMD_SYNC) armed <= 1'b1;
      if (frame_done && live && b0 == CMD_EXT) ext <= b2;
      if (req_valid && !is_read) busy_cnt <= busy_ticks(req_op, 32'(TICK));
      else if (busy) busy_cnt <= busy_cnt - 32'd1;
    end
  end
endmodule

// File: rtl/tsp_target.sv
module tsp_target
  import tsp_pkg::*;
#(
  parameter int FLASH_AW = 10,
  parameter int EE_AW    = 8,
  parameter int PAGE_AW  = 7,
  parameter int TICK     = 1600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_en,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  output logic        busy,
  output logic        req_valid,
  output logic [2:0]  req_op,
  output logic [23:0] req_addr,
  output logic [7:0]  req_data
);
  localparam int PAGE_WORDS = 1 << PAGE_AW;

  logic                        byte_done;
  logic [1:0]                  byte_idx;
  logic [7:0]                  rx_byte, tx_cur, tx_next, rd_data;
  logic                        armed;
  mem_op_e                     op_q;
  logic                        ld_en, ld_hi, buf_clr;
  logic [PAGE_AW-1:0]          ld_idx;
  logic [7:0]                  ld_data;
  logic [PAGE_WORDS-1:0][15:0] page_words;

  assign req_op = op_q;

  tsp_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .mosi(mosi),
    .tx_next(tx_next), .byte_done(byte_done), .byte_idx(byte_idx),
    .rx_byte(rx_byte), .tx_cur(tx_cur), .miso(miso)
  );

  tsp_decode #(.PAGE_AW(PAGE_AW), .TICK(TICK)) u_dec (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .byte_done(byte_done),
    .byte_idx(byte_idx), .rx_byte(rx_byte), .rd_data(rd_data), .tx_next(tx_next),
    .req_valid(req_valid), .req_op(op_q), .req_addr(req_addr), .req_data(req_data),
    .ld_en(ld_en), .ld_hi(ld_hi), .ld_idx(ld_idx), .ld_data(ld_data),
    .buf_clr(buf_clr), .busy(busy), .armed(armed)
  );

  tsp_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_hi(ld_hi), .ld_idx(ld_idx),
    .ld_data(ld_data), .clr(buf_clr), .words(page_words)
  );

  tsp_mem_model #(.FLASH_AW(FLASH_AW), .EE_AW(EE_AW), .PAGE_AW(PAGE_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_q),
    .req_addr(req_addr), .req_data(req_data), .page(page_words), .rd_data(rd_data)
  );
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_en,
  input logic       byte_done,
  input logic [1:0] byte_idx,
  input logic [7:0] rx_byte,
  input logic [7:0] tx_cur,
  input logic       armed,
  input logic       busy,
  input logic       req_valid,
  input logic [2:0] req_op
);
  p_quiet_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !busy);

  p_busy_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op >= 3'd1 && req_op <= 3'd3) |=> busy);

  p_need_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> armed);

  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> (byte_idx == 2'd0 && !armed && tx_cur == 8'h00));

  p_echo_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_idx != 2'd3 && !req_valid) |=> tx_cur == $past(rx_byte));

  p_frame_end_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_idx == 2'd3) |=> tx_cur == 8'h00);

  p_op_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op != 3'd0 && req_op <= 3'd5));
endmodule

bind tsp_target tsp_checker u_chk (.*);

// File: tb/tsp_target_bench.sv
module tsp_target_bench;
  localparam int TICK = 20;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, busy, req_valid;
  logic [2:0] req_op;
  logic [23:0] req_addr;
  logic [7:0] req_data;

  int checks = 0, failures = 0, busy_total = 0;
  logic [2:0]  w_op;
  logic [23:0] w_addr;
  logic [7:0]  w_data;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tsp_target #(.TICK(TICK)) u_tsp_target (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data)
  );

  always @(negedge clk) if (busy) busy_total++;
  always @(posedge clk)
    if (req_valid && req_op >= 3'd1 && req_op <= 3'd3) begin
      w_op <= req_op; w_addr <= req_addr; w_data <= req_data;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] a, b, c, d,
                       output logic [7:0] r1, r2, r3);
    logic [7:0] r0;
    xbyte(a, r0); xbyte(b, r1); xbyte(c, r2); xbyte(d, r3);
  endtask

  task automatic send(input logic [7:0] a, b, c, d);
    logic [7:0] x1, x2, x3;
    frame(a, b, c, d, x1, x2, x3);
  endtask

  task automatic rd(input logic [7:0] op, hi, lo, output logic [7:0] v);
    logic [7:0] x1, x2;
    frame(op, hi, lo, 8'h00, x1, x2, v);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] lo_of(int i); return 8'((i * 7 + 3) & 255); endfunction
  function automatic logic [7:0] hi_of(int i); return 8'(i) ^ 8'hA5; endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] e1, e2, e3, v;
    int b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 0 && req_valid == 0 && miso == 0, "R12 reset", {busy, req_valid, miso}, 0);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);

    // R3: write before arming is ignored
    send(8'hC0, 8'h00, 8'h05, 8'hAA);
    chk(busy == 0, "R3 no busy unarmed", busy, 0);
    // R2 echo of arming instruction
    frame(8'hAC, 8'h53, 8'h6E, 8'h00, e1, e2, e3);
    chk(e1 == 8'hAC, "R2 echo byte1", e1, 8'hAC);
    chk(e2 == 8'h53, "R2 sync echo", e2, 8'h53);
    chk(e3 == 8'h6E, "R2 echo byte3", e3, 8'h6E);
    rd(8'hA0, 8'h00, 8'h05, v);
    chk(v == 8'hFF, "R3 ignored write", v, 8'hFF);

    // R8 / R10 / R12 EEPROM write
    b0 = busy_total;
    send(8'hC0, 8'h00, 8'h05, 8'hAA);
    wait_idle();
    chk(busy_total - b0 == 36 * TICK, "R10 eeprom busy", busy_total - b0, 36 * TICK);
    chk(w_op == 3'd2 && w_addr == 24'h5 && w_data == 8'hAA, "R12 ee req", {w_op, w_addr}, {3'd2, 24'h5});
    rd(8'hA0, 8'h00, 8'h05, v);
    chk(v == 8'hAA, "R8 ee read", v, 8'hAA);
    send(8'hC0, 8'h00, 8'h05, 8'h0F);
    wait_idle();
    rd(8'hA0, 8'h00, 8'h05, v);
    chk(v == 8'h0F, "R8 replace", v, 8'h0F);

    // R11 ignored while busy
    send(8'hC0, 8'h00, 8'h06, 8'h33);
    send(8'hC0, 8'h00, 8'h06, 8'h77);
    chk(busy == 1, "R11 still busy", busy, 1);
    wait_idle();
    rd(8'hA0, 8'h00, 8'h06, v);
    chk(v == 8'h33, "R11 busy ignore", v, 8'h33);

    // R4 page loads (word 5 high first, word 6 low only)
    for (int i = 0; i < 128; i++) begin
      if (i == 5) begin
        send(8'h48, 8'h00, 8'(i), 8'h12);
        send(8'h40, 8'h00, 8'(i), lo_of(i));
      end else if (i == 6) begin
        send(8'h40, 8'h00, 8'(i), lo_of(i));
      end else begin
        send(8'h40, 8'h00, 8'(i), lo_of(i));
        send(8'h48, 8'h00, 8'(i), hi_of(i));
      end
    end
    b0 = busy_total;
    send(8'h4C, 8'h00, 8'h85, 8'h00);  // R5 low bits ignored
    wait_idle();
    chk(busy_total - b0 == 45 * TICK, "R10 page busy", busy_total - b0, 45 * TICK);
    chk(w_op == 3'd1 && w_addr == 24'h85, "R12 page req", {w_op, w_addr}, {3'd1, 24'h85});
    for (int i = 0; i < 128; i++) begin
      rd(8'h20, 8'h00, 8'(8'h80 + i), v);
      chk(v == lo_of(i), "R7 low sweep", v, lo_of(i));
      if (i % 8 == 0 || i == 5 || i == 6 || i == 127) begin
        logic [7:0] eh;
        eh = (i == 5 || i == 6) ? 8'hFF : hi_of(i);
        rd(8'h28, 8'h00, 8'(8'h80 + i), v);
        chk(v == eh, "R4 high half", v, eh);
      end
    end

    // R5 buffer cleared after commit
    send(8'h4C, 8'h01, 8'h00, 8'h00);
    wait_idle();
    rd(8'h20, 8'h01, 8'h00, v);
    chk(v == 8'hFF, "R5 cleared low", v, 8'hFF);
    rd(8'h28, 8'h01, 8'h7F, v);
    chk(v == 8'hFF, "R5 cleared high", v, 8'hFF);

    // R6 sticky extended byte
    send(8'h4D, 8'h00, 8'h01, 8'h00);
    send(8'h40, 8'h00, 8'h03, 8'hC3);
    send(8'h48, 8'h00, 8'h03, 8'h3C);
    send(8'h4C, 8'h00, 8'h00, 8'h00);
    wait_idle();
    chk(w_addr == 24'h010000, "R6 page addr", w_addr, 24'h010000);
    rd(8'h20, 8'h00, 8'h03, v);
    chk(v == 8'hC3, "R6 ext read low", v, 8'hC3);
    rd(8'h28, 8'h00, 8'h03, v);
    chk(v == 8'h3C, "R6 ext sticky", v, 8'h3C);
    send(8'h4D, 8'h00, 8'h00, 8'h00);
    rd(8'h20, 8'h00, 8'h03, v);
    chk(v == 8'hFF, "R6 ext zero", v, 8'hFF);

    // R1 prog_en low resets framing and arming
    xbyte(8'hC0, v); xbyte(8'h00, v);
    prog_en = 1'b0;
    repeat (6) @(negedge clk);
    chk(miso == 0, "R1 miso cleared", miso, 0);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);
    send(8'hC0, 8'h00, 8'h07, 8'h11);
    chk(busy == 0, "R1 disarmed", busy, 0);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, e1, e2, e3);
    chk(e2 == 8'h53, "R1 realigned", e2, 8'h53);
    rd(8'hA0, 8'h00, 8'h07, v);
    chk(v == 8'hFF, "R1 write dropped", v, 8'hFF);

    // R9 chip erase
    b0 = busy_total;
    send(8'hAC, 8'h80, 8'h00, 8'h00);
    wait_idle();
    chk(busy_total - b0 == 90 * TICK, "R10 erase busy", busy_total - b0, 90 * TICK);
    rd(8'hA0, 8'h00, 8'h05, v);
    chk(v == 8'hFF, "R9 ee erased", v, 8'hFF);
    rd(8'h20, 8'h00, 8'h81, v);
    chk(v == 8'hFF, "R9 flash erased", v, 8'hFF);

    report();
  end
endmodule